// File: doc/BRIEF.md
# Limit-Match Interval Counter

This block is a memory-mapped interval timer. An internal count lives in the bits just above bit 8 of a 32-bit word and moves up by one unit of bit 9 (0x200) each time the tick strobe is high. The tick strobe comes from an external divider that pulses once every 500 ns. Bits 8..0 of the count always read as zero.

Software programs a limit. When the count reaches a nonzero limit, the block sets a sticky reached flag, shown in bit 31 of the counter word, and raises a level interrupt. It then restarts the count from 0x200. A limit of zero puts the counter in free-run: it climbs to the top of its field and wraps, and it never sets the flag or the interrupt. Software acknowledges a match by reading the limit word. That read clears both the flag and the interrupt line.

The count field is `CNT_W` bits wide (default 22, word bits 30..9). Below, FMAX is the count value with every field bit set (0x7FFFFE00 at the default width), and the limit field is `busWdata & FMAX`.

Top module: `itmr_top`

## Requirements
- R1: After reset, the limit word (byte offset 0x0) reads 0, the counter word (byte offset 0x4) reads 0, and `irq` is low.
- R2: Each cycle with `tickEn` high adds 0x200 to the count. The count is unchanged in cycles without a tick, and bits 8..0 of the counter word are always zero.
- R3: On the tick that brings the count equal to a nonzero limit, bit 31 of the counter word becomes 1 and `irq` rises on the following edge. The next tick loads 0x200 into the count.
- R4: With a limit of zero, the count rises to FMAX and the next tick loads 0x200. In this mode neither the flag nor `irq` is ever set.
- R5: A write to byte offset 0x0 loads the limit field, clears the count to 0 and drops `irq`. It leaves the flag unchanged. If a tick arrives in the same cycle, the write wins.
- R6: A write to byte offset 0x8 loads the limit field and leaves the count running. A tick in the same cycle still advances the count, compared against the old limit.
- R7: A read of byte offset 0x0 returns the limit field (bit 31 zero). It clears the flag and `irq` on the clock edge that ends the read, unless a match happens on that same edge, in which case the match wins.
- R8: A read of byte offset 0x4 returns the count ORed with the flag in bit 31. This read has no side effect.
- R9: An access to byte offsets 0xC–0x1C, a misaligned address (bits 1..0 nonzero), or an access with any byte enable low reads as 0 and changes no state.
- R10: Once `irq` is high, it stays high until a read of 0x0 or a write of 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count strobe, one pulse per 500 ns |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address |
| busByteEn | input | 4 | Byte enables; all four must be set |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid combinationally while the read is presented |
| irq | output | 1 | Level interrupt on a limit match |

## Verification
The counter is first driven by steady ticks with no bus traffic. This isolates the step size and the hold behaviour from any register side effect. Small nonzero limits then force frequent matches, so the wrap to 0x200 and the sticky flag can be seen, along with the difference between acknowledging by read and reloading by write. A long free-run with a narrowed count field checks the top-of-range wrap and confirms that no flag appears. A random mix then places writes, acknowledges and ticks in the same cycle, which separates the precedence rules from the plain sequential behaviour. Malformed accesses are interleaved throughout to show that they leave the state untouched.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef struct packed {
    logic tickAdvance;
    logic loadRestart;
    logic loadKeep;
    logic ackRead;
  } itmrStrobes_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic              hit,
  output itmrStrobes_t      strobes,
  output logic              rdSelLimit,
  output logic              rdSelCount,
  output logic              flag,
  output logic              irq
);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_COUNT = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_KEEP  = OFF_W'(2);

  logic             wordAccess;
  logic [OFF_W-1:0] wordOff;

  assign wordOff    = busAddr[ADDR_W-1:2];
  assign wordAccess = busValid && (busAddr[1:0] == 2'b00) && (&busByteEn);

  always_comb begin
    strobes.tickAdvance = tickEn;
    strobes.loadRestart = wordAccess && busWrite && (wordOff == OFF_LIMIT);
    strobes.loadKeep    = wordAccess && busWrite && (wordOff == OFF_KEEP);
    strobes.ackRead     = wordAccess && !busWrite && (wordOff == OFF_LIMIT);
    rdSelLimit          = strobes.ackRead;
    rdSelCount          = wordAccess && !busWrite && (wordOff == OFF_COUNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (hit)                  flag <= 1'b1;
      else if (strobes.ackRead) flag <= 1'b0;
      if (hit)                                          irq <= 1'b1;
      else if (strobes.ackRead || strobes.loadRestart)  irq <= 1'b0;
    end
  end

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq && !strobes.ackRead && !strobes.loadRestart |=> irq);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackRead && !hit |=> !flag && !irq);

  assert_irq_has_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  assert_hit_raises_R3: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> irq && flag);
endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  itmrStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSelLimit,
  input  logic              rdSelCount,
  input  logic              flag,
  output logic              hit,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam int PAD_W = DATA_W - 1 - CNT_W - FRAC_W;

  logic [CNT_W-1:0] cnt, lim, effLim, nextCnt, wrField;
  logic             atTop;

  assign wrField = wrData[FRAC_W +: CNT_W];
  assign effLim  = (lim == '0) ? CNT_MAX : lim;
  assign atTop   = (cnt == effLim) || (cnt == CNT_MAX);
  assign nextCnt = atTop ? CNT_ONE : cnt + CNT_ONE;
  assign hit     = strobes.tickAdvance && !strobes.loadRestart &&
                   (lim != '0) && (nextCnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      if (strobes.loadRestart)      cnt <= '0;
      else if (strobes.tickAdvance) cnt <= nextCnt;
      if (strobes.loadRestart || strobes.loadKeep) lim <= wrField;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (rdSelLimit)      rdData = {1'b0, {PAD_W{1'b0}}, lim, {FRAC_W{1'b0}}};
        else if (rdSelCount) rdData = {flag, {PAD_W{1'b0}}, cnt, {FRAC_W{1'b0}}};
        else                 rdData = '0;
      end
    end else begin : g_nopad
      always_comb begin
        if (rdSelLimit)      rdData = {1'b0, lim, {FRAC_W{1'b0}}};
        else if (rdSelCount) rdData = {flag, cnt, {FRAC_W{1'b0}}};
        else                 rdData = '0;
      end
    end
  endgenerate

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tickAdvance && !strobes.loadRestart && (cnt != CNT_MAX) && (cnt != effLim)
    |=> cnt == CNT_W'($past(cnt) + CNT_ONE));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tickAdvance && !strobes.loadRestart |=> $stable(cnt));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRestart |=> cnt == '0);

  assert_keep_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadKeep |=> lim == $past(wrField));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tickAdvance && !strobes.loadRestart && (cnt == effLim) |=> cnt == CNT_ONE);
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int FRAC_W = 9,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  itmrStrobes_t strobes;
  logic rdSelLimit, rdSelCount, flag, hit;

  itmr_ctrl #(.ADDR_W(ADDR_W), .BE_W(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busByteEn(busByteEn),
    .hit(hit), .strobes(strobes), .rdSelLimit(rdSelLimit),
    .rdSelCount(rdSelCount), .flag(flag), .irq(irq)
  );

  itmr_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWdata),
    .rdSelLimit(rdSelLimit), .rdSelCount(rdSelCount), .flag(flag),
    .hit(hit), .rdData(busRdata)
  );
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
  localparam int CW = 10;
  localparam logic [31:0] FMAX = ((32'd1 << CW) - 32'd1) << 9;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq;

  int nChecks = 0, nFail = 0;
  logic [31:0] mLim = '0, mCnt = '0;
  logic mFlag = 1'b0, mIrq = 1'b0;

  always #10 clk = ~clk;

  itmr_top #(.DATA_W(32), .ADDR_W(5), .FRAC_W(9), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  function automatic logic isWord(logic v, logic [4:0] a, logic [3:0] be);
    return v && (a[1:0] == 2'b00) && (be == 4'hF);
  endfunction

  function automatic logic [31:0] expRead(logic [4:0] a, logic [3:0] be);
    if (!isWord(1'b1, a, be)) return 32'h0;
    if (a[4:2] == 3'd0) return mLim;
    if (a[4:2] == 3'd1) return {mFlag, 31'h0} | mCnt;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge(input logic v, input logic w, input logic [4:0] a,
                           input logic [3:0] be, input logic [31:0] wd, input logic tk);
    logic word, w0, w2, r0, hit;
    logic [31:0] eff, nxt;
    word = isWord(v, a, be);
    w0 = word && w && a[4:2] == 3'd0;
    w2 = word && w && a[4:2] == 3'd2;
    r0 = word && !w && a[4:2] == 3'd0;
    eff = (mLim == 0) ? FMAX : mLim;
    hit = 1'b0;
    if (w0) mCnt = 32'h0;
    else if (tk) begin
      nxt = (mCnt == eff || mCnt == FMAX) ? 32'h200 : mCnt + 32'h200;
      hit = (mLim != 0) && (nxt == eff);
      mCnt = nxt;
    end
    if (w0 || w2) mLim = wd & FMAX;
    if (hit) mFlag = 1'b1; else if (r0) mFlag = 1'b0;
    if (hit) mIrq = 1'b1; else if (r0 || w0) mIrq = 1'b0;
  endtask

  task automatic step(input logic v, input logic w, input logic [4:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input logic tk,
                      input string tag);
    string t;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busByteEn = be; busWdata = wd; tickEn = tk;
    #1;
    check("R10 irq level", {31'h0, irq}, {31'h0, mIrq});
    if (v && !w) begin
      if (tag != "") t = tag;
      else if (!isWord(1'b1, a, be) || a[4:2] > 3'd1) t = "R9";
      else if (a[4:2] == 3'd0) t = "R7";
      else t = "R8";
      check(t, busRdata, expRead(a, be));
    end
    @(posedge clk);
    modelEdge(v, w, a, be, wd, tk);
  endtask

  task automatic idle(input logic tk);
    step(1'b0, 1'b0, 5'h0, 4'hF, 32'h0, tk, "");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b1, 1'b0, a, 4'hF, 32'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic tk);
    step(1'b1, 1'b1, a, 4'hF, d, tk, "");
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    rd(5'h0, "R1"); rd(5'h4, "R1");
    check("R1 irq", {31'h0, irq}, 32'h0);
    // R2 stepping and holding
    repeat (5) idle(1'b1);
    rd(5'h4, "R2");
    check("R2 literal", busRdata, 32'hA00);
    repeat (3) idle(1'b0);
    rd(5'h4, "R2");
    // R3 match, sticky flag, wrap
    wr(5'h0, 32'h0000_0600, 1'b0);
    repeat (3) idle(1'b1);
    rd(5'h4, "R3");
    check("R3 literal", busRdata, 32'h8000_0600);
    idle(1'b1);
    rd(5'h4, "R3");
    check("R3 wrap", busRdata, 32'h8000_0200);
    // R10 hold
    repeat (4) idle(1'b0);
    check("R10 held", {31'h0, irq}, 32'h1);
    // R7 acknowledge
    rd(5'h0, "R7");
    rd(5'h4, "R7");
    check("R7 cleared", {31'h0, irq}, 32'h0);
    // R5 restart keeps flag, wins over tick
    wr(5'h0, 32'h0000_0400, 1'b0);
    repeat (2) idle(1'b1);
    wr(5'h0, 32'hFFFF_FFFF, 1'b1);
    rd(5'h4, "R5");
    check("R5 literal", busRdata, 32'h8000_0000);
    rd(5'h0, "R5");
    // R6 limit without restart
    repeat (3) idle(1'b1);
    wr(5'h8, 32'h0000_1000, 1'b1);
    rd(5'h4, "R6");
    rd(5'h0, "R6");
    // R9 malformed and unmapped
    wr(5'h0C, 32'h0000_0200, 1'b0);
    wr(5'h10, 32'h0000_0200, 1'b0);
    step(1'b1, 1'b1, 5'h0, 4'h7, 32'h0000_0200, 1'b0, "");
    step(1'b1, 1'b1, 5'h1, 4'hF, 32'h0000_0200, 1'b0, "");
    rd(5'h0, "R9"); rd(5'h4, "R9");
    rd(5'h0C, "R9"); rd(5'h1C, "R9");
    step(1'b1, 1'b0, 5'h4, 4'h3, 32'h0, 1'b0, "R9");
    // R4 free-run to top and wrap, no flag
    wr(5'h0, 32'h0, 1'b0);
    repeat ((1 << CW) - 1) idle(1'b1);
    rd(5'h4, "R4");
    check("R4 top", busRdata, FMAX);
    idle(1'b1);
    rd(5'h4, "R4");
    check("R4 wrap", busRdata, 32'h200);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic v, w, tk;
      logic [4:0] a;
      logic [3:0] be;
      logic [31:0] d;
      int sel;
      tk = ($urandom % 2) == 0;
      v = ($urandom % 3) == 0;
      w = ($urandom % 2) == 0;
      sel = $urandom % 16;
      a = (sel < 5) ? 5'h0 : (sel < 10) ? 5'h4 : (sel < 13) ? 5'h8 : 5'($urandom);
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      d = (($urandom % 6) == 0) ? 32'h0 : (32'($urandom % 12) << 9) | 32'($urandom % 512);
      step(v, w, a, be, d, tk, "");
    end
    finishRun();
  end
endmodule